// File: doc/BRIEF.md
# Uplink Timing Advance Controller

This block holds a terminal's uplink transmit timing advance as an unsigned count of eighth-chip units. It sets the advance in three ways:

- **Random access load.** It loads an initial value from the terminal's own probe advance and the received position value reported back by the network.
- **Handover load.** It recomputes the value from a measured time difference between the new cell and the old cell.
- **Closed-loop commands.** In connected mode it receives synchronization-shift commands, one or more per subframe. Each command either keeps the value, raises it by a configured step or lowers it by that step.

A closed-loop command does not act at once. It waits for a configured number of ordinary timeslots, and special timeslots are not counted. A timeslot boundary is signalled by `slotTick`. `slotSpecial` marks the pilot and guard slots, so those boundaries can be skipped in the count.

When a command arrives while another is still waiting, it goes into a small waiting buffer. If that buffer is already full, the oldest waiting entry is dropped and a sticky flag is raised. Either load pulse discards all closed-loop work in progress.

Top module: `ul_ta_ctrl`

## Requirements
- R1: After reset, `taValue` is 0, no command is pending and `ovfSticky` is 0. Without a load pulse or an applied command, `taValue` does not change.
- R2: Command code 2'b01 raises the advance by the step. Code 2'b10 lowers it by the step. Codes 2'b00 (hold) and 2'b11 (reserved) are discarded and never change `taValue`.
- R3: The step is `cfgStepK` eighth-chips for values 1 to 8. A value of 0 acts as 1, and values above 8 act as 8.
- R4: The active command applies on the Nth boundary with `slotTick`=1 and `slotSpecial`=0, counted from the cycle after it became active. N is `cfgDelayN` for values 1 to 6; 0 acts as 1 and 7 acts as 6. Boundaries with `slotSpecial`=1 are not counted. `taValue` shows the change on the clock edge that ends the applying cycle.
- R5: Up to two further commands wait, in arrival order, behind the active command. A waiting command becomes active in the cycle after its predecessor applies and starts its own count there. A command that arrives in the same cycle as an apply is handled after that apply.
- R6: When two commands already wait and another arrives, the oldest waiting one is dropped and the new one is appended. `ovfSticky` then goes to 1 and stays there until reset.
- R7: A `raLoad` pulse sets `taValue` on the next edge to `raProbeAdv + raRxPos - 128`.
- R8: A `hoLoad` pulse with `hoEnable`=1 sets `taValue` to the old value plus twice `hoDeltaT`, where `hoDeltaT` is read as two's complement. With `hoEnable`=0 the pulse is ignored.
- R9: A load pulse clears the active command and all waiting commands. Any command offered in the same cycle is also discarded. `raLoad` takes priority over `hoLoad`.
- R10: Every new value is saturated to the range 0 to 2^TA_W-1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 2 | Command code: 00 hold, 01 up, 10 down, 11 reserved |
| slotTick | input | 1 | Timeslot boundary strobe |
| slotSpecial | input | 1 | The boundary belongs to a special slot |
| cfgStepK | input | 4 | Step size in eighth-chips |
| cfgDelayN | input | 3 | Number of ordinary slots before a command applies |
| raLoad | input | 1 | Random access load strobe |
| raProbeAdv | input | TA_W | Terminal's own probe advance |
| raRxPos | input | TA_W | Received position value reported by the network |
| hoLoad | input | 1 | Handover load strobe |
| hoEnable | input | 1 | Enables handover recomputation |
| hoDeltaT | input | TA_W | Signed time difference between the new and old cell |
| taValue | output | TA_W | Current advance in eighth-chip units |
| ovfSticky | output | 1 | Sticky flag for a dropped waiting command |

## Verification
Two pairs of events can land in the same clock cycle:

- **Load and pending command.** A load pulse can coincide with an apply or a new command.
- **Apply and new command.** An apply can coincide with the arrival of a new command that must queue behind it.

Both collisions are provoked on purpose. Directed tests place a load exactly on the cycle when a pending command reaches its Nth ordinary slot, and issue a command on that same cycle while the buffer is full. A long random phase then mixes dense commands, ticks, special slots and rare loads.

Every cycle is judged against a behavioural queue model. The checks confirm that the load wins, that the queue is emptied, and that an apply and an enqueue in one cycle leave the value and the overflow flag exactly as the model predicts.

// File: rtl/ul_ta_pkg.sv
package ul_ta_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'b00,
    CMD_UP   = 2'b01,
    CMD_DOWN = 2'b10,
    CMD_RSVD = 2'b11
  } ssCmd_t;

  // Strobes from control to datapath; at most one is set in a cycle
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic raLd;
    logic hoLd;
  } taStrobe_t;

endpackage

// File: rtl/ul_ta_ctrl_seq.sv
module ul_ta_ctrl_seq
  import ul_ta_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdCode,
  input  logic       slotTick,
  input  logic       slotSpecial,
  input  logic [2:0] cfgDelayN,
  input  logic       raLoad,
  input  logic       hoLoad,
  input  logic       hoEnable,
  output taStrobe_t  strb,
  output logic       ovfSticky
);

  localparam int WAIT_D = 2;

  logic              actValid, actUp;
  logic [2:0]        cnt;
  logic [WAIT_D-1:0] wValid, wUp;   // index 0 is the oldest waiting entry

  logic              nAct, nActUp, nOvf;
  logic [2:0]        nCnt, delayEff;
  logic [WAIT_D-1:0] nW, nWUp;
  logic              loadRa, loadHo, anyLoad, ordTick, fire, newCmd, newUp;

  always_comb begin
    if (cfgDelayN == 3'd0)      delayEff = 3'd1;
    else if (cfgDelayN == 3'd7) delayEff = 3'd6;
    else                        delayEff = cfgDelayN;
  end

  assign loadRa  = raLoad;
  assign loadHo  = hoLoad && hoEnable && !raLoad;
  assign anyLoad = loadRa || loadHo;
  assign ordTick = slotTick && !slotSpecial;
  assign fire    = actValid && ordTick && !anyLoad &&
                   (({1'b0, cnt} + 4'd1) >= {1'b0, delayEff});
  assign newCmd  = cmdValid && (cmdCode == CMD_UP || cmdCode == CMD_DOWN);
  assign newUp   = (cmdCode == CMD_UP);

  always_comb begin
    nAct   = actValid;
    nActUp = actUp;
    nCnt   = cnt;
    nW     = wValid;
    nWUp   = wUp;
    nOvf   = ovfSticky;
    if (anyLoad) begin
      nAct = 1'b0;
      nCnt = 3'd0;
      nW   = '0;
    end else begin
      if (fire) begin
        nAct    = wValid[0];
        nActUp  = wUp[0];
        nW[0]   = wValid[1];
        nWUp[0] = wUp[1];
        nW[1]   = 1'b0;
        nCnt    = 3'd0;
      end else if (actValid && ordTick) begin
        nCnt = cnt + 3'd1;
      end
      if (newCmd) begin
        if (!nAct) begin
          nAct   = 1'b1;
          nActUp = newUp;
          nCnt   = 3'd0;
        end else if (!nW[0]) begin
          nW[0]   = 1'b1;
          nWUp[0] = newUp;
        end else if (!nW[1]) begin
          nW[1]   = 1'b1;
          nWUp[1] = newUp;
        end else begin
          nWUp[0] = nWUp[1];
          nWUp[1] = newUp;
          nOvf    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actValid  <= 1'b0;
      actUp     <= 1'b0;
      cnt       <= 3'd0;
      wValid    <= '0;
      wUp       <= '0;
      ovfSticky <= 1'b0;
    end else begin
      actValid  <= nAct;
      actUp     <= nActUp;
      cnt       <= nCnt;
      wValid    <= nW;
      wUp       <= nWUp;
      ovfSticky <= nOvf;
    end
  end

  always_comb begin
    strb.stepUp = fire && actUp;
    strb.stepDn = fire && !actUp;
    strb.raLd   = loadRa;
    strb.hoLd   = loadHo;
  end

  // R5: waiting entries fill in order behind an active command
  p_wait_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    wValid[1] |-> (wValid[0] && actValid));

  // R4: a step is only issued on an ordinary slot boundary
  p_fire_ordinary_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp || strb.stepDn) |-> (slotTick && !slotSpecial));

  // R9: a load leaves nothing pending
  p_load_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (raLoad || (hoLoad && hoEnable)) |=> (!actValid && wValid == '0));

  // R6: overflow flag is sticky
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovfSticky |=> ovfSticky);

endmodule

// File: rtl/ul_ta_dpath.sv
module ul_ta_dpath
  import ul_ta_pkg::*;
#(
  parameter int TA_W = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  taStrobe_t       strb,
  input  logic [3:0]      cfgStepK,
  input  logic [TA_W-1:0] raProbeAdv,
  input  logic [TA_W-1:0] raRxPos,
  input  logic [TA_W-1:0] hoDeltaT,
  output logic [TA_W-1:0] taValue
);

  localparam int EXT_W = TA_W + 3;
  localparam logic signed [EXT_W-1:0] MAX_EXT = {3'b000, {TA_W{1'b1}}};
  localparam logic signed [EXT_W-1:0] RA_BIAS = EXT_W'(128);

  logic [3:0]              stepEff;
  logic signed [EXT_W-1:0] taExt, stepExt, raSum, hoSum, upSum, dnSum;

  always_comb begin
    if (cfgStepK == 4'd0)      stepEff = 4'd1;
    else if (cfgStepK > 4'd8)  stepEff = 4'd8;
    else                       stepEff = cfgStepK;
  end

  function automatic logic [TA_W-1:0] satTa(input logic signed [EXT_W-1:0] v);
    if (v[EXT_W-1])       return '0;
    else if (v > MAX_EXT) return {TA_W{1'b1}};
    else                  return v[TA_W-1:0];
  endfunction

  assign taExt   = $signed({3'b000, taValue});
  assign stepExt = $signed({{(EXT_W-4){1'b0}}, stepEff});
  assign raSum   = $signed({3'b000, raProbeAdv}) + $signed({3'b000, raRxPos}) - RA_BIAS;
  assign hoSum   = taExt + $signed({{2{hoDeltaT[TA_W-1]}}, hoDeltaT, 1'b0});
  assign upSum   = taExt + stepExt;
  assign dnSum   = taExt - stepExt;

  always_ff @(posedge clk) begin
    if (!rstN)            taValue <= '0;
    else if (strb.raLd)   taValue <= satTa(raSum);
    else if (strb.hoLd)   taValue <= satTa(hoSum);
    else if (strb.stepUp) taValue <= satTa(upSum);
    else if (strb.stepDn) taValue <= satTa(dnSum);
  end

  // R9: control never issues two actions at once
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stepUp, strb.stepDn, strb.raLd, strb.hoLd}));

  // R2: an up step never lowers the advance
  p_up_monotone_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepUp |=> (taValue >= $past(taValue)));

  // R2: a down step never raises the advance
  p_dn_monotone_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepDn |=> (taValue <= $past(taValue)));

  // R1: without any strobe the advance holds
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.stepUp || strb.stepDn || strb.raLd || strb.hoLd) |=> $stable(taValue));

endmodule

// File: rtl/ul_ta_ctrl.sv
module ul_ta_ctrl
  import ul_ta_pkg::*;
#(
  parameter int TA_W = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdCode,
  input  logic            slotTick,
  input  logic            slotSpecial,
  input  logic [3:0]      cfgStepK,
  input  logic [2:0]      cfgDelayN,
  input  logic            raLoad,
  input  logic [TA_W-1:0] raProbeAdv,
  input  logic [TA_W-1:0] raRxPos,
  input  logic            hoLoad,
  input  logic            hoEnable,
  input  logic [TA_W-1:0] hoDeltaT,
  output logic [TA_W-1:0] taValue,
  output logic            ovfSticky
);

  taStrobe_t strb;

  ul_ta_ctrl_seq i_seq (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .slotTick   (slotTick),
    .slotSpecial(slotSpecial),
    .cfgDelayN  (cfgDelayN),
    .raLoad     (raLoad),
    .hoLoad     (hoLoad),
    .hoEnable   (hoEnable),
    .strb       (strb),
    .ovfSticky  (ovfSticky)
  );

  ul_ta_dpath #(.TA_W(TA_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgStepK  (cfgStepK),
    .raProbeAdv(raProbeAdv),
    .raRxPos   (raRxPos),
    .hoDeltaT  (hoDeltaT),
    .taValue   (taValue)
  );

endmodule

// File: tb/test_ul_ta_ctrl.sv
module test_ul_ta_ctrl;

  localparam int TA_W  = 14;
  localparam int TAMAX = (1 << TA_W) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdValid = 1'b0;
  logic [1:0]      cmdCode = 2'b00;
  logic            slotTick = 1'b0;
  logic            slotSpecial = 1'b0;
  logic [3:0]      cfgStepK = 4'd3;
  logic [2:0]      cfgDelayN = 3'd2;
  logic            raLoad = 1'b0;
  logic [TA_W-1:0] raProbeAdv = '0;
  logic [TA_W-1:0] raRxPos = '0;
  logic            hoLoad = 1'b0;
  logic            hoEnable = 1'b0;
  logic [TA_W-1:0] hoDeltaT = '0;
  logic [TA_W-1:0] taValue;
  logic            ovfSticky;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;
  string curReq  = "R1";

  always #4 clk = ~clk;   // 125 MHz

  ul_ta_ctrl #(.TA_W(TA_W)) i_ul_ta_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .slotTick(slotTick), .slotSpecial(slotSpecial), .cfgStepK(cfgStepK),
    .cfgDelayN(cfgDelayN), .raLoad(raLoad), .raProbeAdv(raProbeAdv),
    .raRxPos(raRxPos), .hoLoad(hoLoad), .hoEnable(hoEnable),
    .hoDeltaT(hoDeltaT), .taValue(taValue), .ovfSticky(ovfSticky)
  );

  // Behavioural reference: q[0] is the active command, the rest wait (1 = up, 0 = down)
  int mTa, mCnt, nEff, kEff, d;
  bit mOvf;
  int q[$];

  function automatic int clampTa(input int v);
    if (v < 0) return 0;
    if (v > TAMAX) return TAMAX;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTa = 0; mCnt = 0; mOvf = 1'b0; q.delete();
    end else begin
      nEff = (cfgDelayN == 0) ? 1 : (cfgDelayN == 7) ? 6 : int'(cfgDelayN);
      kEff = (cfgStepK == 0) ? 1 : (cfgStepK > 8) ? 8 : int'(cfgStepK);
      if (raLoad) begin
        mTa = clampTa(int'(raProbeAdv) + int'(raRxPos) - 128);
        q.delete(); mCnt = 0;
      end else if (hoLoad && hoEnable) begin
        d = $signed(hoDeltaT);
        mTa = clampTa(mTa + 2 * d);
        q.delete(); mCnt = 0;
      end else begin
        if (q.size() > 0 && slotTick && !slotSpecial) begin
          if (mCnt + 1 >= nEff) begin
            mTa = clampTa(q[0] ? mTa + kEff : mTa - kEff);
            void'(q.pop_front());
            mCnt = 0;
          end else begin
            mCnt++;
          end
        end
        if (cmdValid && (cmdCode == 2'b01 || cmdCode == 2'b10)) begin
          if (q.size() == 0) mCnt = 0;
          if (q.size() == 3) begin
            q.delete(1);
            mOvf = 1'b1;
          end
          q.push_back(cmdCode == 2'b01 ? 1 : 0);
        end
      end
    end
  end

  // Compare on every falling edge after reset
  always @(negedge clk) begin
    if (rstN && !done) begin
      nChecks++;
      if (taValue !== TA_W'(mTa) || ovfSticky !== mOvf) begin
        nFails++;
        $display("FAIL %s: taValue=%0d ovf=%0b expected taValue=%0d ovf=%0b",
                 curReq, taValue, ovfSticky, mTa, mOvf);
      end
    end
  end

  task automatic cyc(input bit cv, input logic [1:0] cc, input bit tk, input bit sp);
    cmdValid = cv; cmdCode = cc; slotTick = tk; slotSpecial = sp;
    @(negedge clk);
    cmdValid = 1'b0; slotTick = 1'b0; slotSpecial = 1'b0;
  endtask

  task automatic raPulse(input int probe, input int pos, input bit cv, input bit tk);
    raLoad = 1'b1; raProbeAdv = TA_W'(probe); raRxPos = TA_W'(pos);
    cyc(cv, 2'b01, tk, 1'b0);
    raLoad = 1'b0;
  endtask

  task automatic hoPulse(input int delta, input bit en, input bit alsoRa);
    hoLoad = 1'b1; hoEnable = en; hoDeltaT = TA_W'(delta); raLoad = alsoRa;
    cyc(1'b0, 2'b00, 1'b0, 1'b0);
    hoLoad = 1'b0; raLoad = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n, input bit sp);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 2'b00, 1'b1, sp);
      cyc(1'b0, 2'b00, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports while reset is held
    nChecks++;
    if (taValue !== '0 || ovfSticky !== 1'b0) begin
      nFails++;
      $display("FAIL R1: taValue=%0d ovf=%0b expected taValue=0 ovf=0", taValue, ovfSticky);
    end
    rstN = 1'b1;
    idle(3);

    curReq = "R7";  raPulse(500, 100, 1'b0, 1'b0); idle(2);          // 472
    curReq = "R2";  cyc(1'b1, 2'b01, 1'b0, 1'b0);
    curReq = "R4";  ticks(2, 1'b1); ticks(3, 1'b0);                  // specials skipped
    curReq = "R2";  cyc(1'b1, 2'b00, 1'b0, 1'b0); cyc(1'b1, 2'b11, 1'b0, 1'b0); ticks(4, 1'b0);
    cyc(1'b1, 2'b10, 1'b0, 1'b0); ticks(3, 1'b0);
    curReq = "R3";  cfgStepK = 4'd0; cyc(1'b1, 2'b01, 1'b0, 1'b0); ticks(3, 1'b0);
    cfgStepK = 4'd12; cyc(1'b1, 2'b01, 1'b0, 1'b0); ticks(3, 1'b0);
    cfgStepK = 4'd5;
    curReq = "R4";  cfgDelayN = 3'd0; cyc(1'b1, 2'b10, 1'b0, 1'b0); ticks(2, 1'b0);
    cfgDelayN = 3'd7; cyc(1'b1, 2'b01, 1'b0, 1'b0); ticks(8, 1'b0);
    cfgDelayN = 3'd1;
    curReq = "R5";  cyc(1'b1, 2'b01, 1'b0, 1'b0); cyc(1'b1, 2'b10, 1'b0, 1'b0);
    cyc(1'b1, 2'b01, 1'b1, 1'b0);                                   // apply and enqueue together
    ticks(4, 1'b0);
    curReq = "R6";  cfgDelayN = 3'd3;
    for (int i = 0; i < 5; i++) cyc(1'b1, (i % 2 == 0) ? 2'b01 : 2'b10, 1'b0, 1'b0);
    ticks(12, 1'b0);
    curReq = "R9";  cyc(1'b1, 2'b01, 1'b0, 1'b0); ticks(2, 1'b0);
    raPulse(300, 200, 1'b1, 1'b1);                                   // load on the apply cycle
    ticks(6, 1'b0);
    hoPulse(40, 1'b1, 1'b1);                                         // RA wins over HO
    curReq = "R8";  hoPulse(-50, 1'b1, 1'b0); hoPulse(77, 1'b0, 1'b0); hoPulse(123, 1'b1, 1'b0);
    curReq = "R10"; raPulse(10, 10, 1'b0, 1'b0); cyc(1'b1, 2'b10, 1'b0, 1'b0); ticks(3, 1'b0);
    raPulse(TAMAX, TAMAX, 1'b0, 1'b0); cyc(1'b1, 2'b01, 1'b0, 1'b0); ticks(3, 1'b0);
    hoPulse(-8000, 1'b1, 1'b0); hoPulse(-8000, 1'b1, 1'b0);

    curReq = "R5";
    for (int i = 0; i < 6000; i++) begin
      if (i % 500 == 0) begin
        cfgDelayN = 3'($urandom % 8);
        cfgStepK  = 4'($urandom % 16);
      end
      raLoad     = ($urandom % 97 == 0);
      raProbeAdv = TA_W'($urandom);
      raRxPos    = TA_W'($urandom % 512);
      hoLoad     = ($urandom % 89 == 0);
      hoEnable   = $urandom % 2;
      hoDeltaT   = TA_W'($urandom % 256 - 128);
      cyc($urandom % 3 == 0, 2'($urandom % 4), $urandom % 2, $urandom % 4 == 0);
      raLoad = 1'b0; hoLoad = 1'b0;
    end
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule